// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Controller

This block sits on the host side of a serial NOR flash and reads a run of consecutive bytes with the dual-output fast read command. A requester gives a 24-bit start address and a byte count on a valid/ready request port. The controller then pulls chip select low and runs the serial clock. It first shifts the command, the address and eight dummy clocks out on the single host-to-flash line. It then releases that line and collects two bits per serial clock, one from each data line. Each finished byte goes out on a valid/ready byte stream.

The serial clock runs in SPI mode 0: it idles low, the controller samples on the rising edge and changes what it drives on the falling edge. The serial clock half period is a whole number of system clocks, set by a parameter. The flash advances its own address, so a single transaction returns any number of bytes. If the consumer of the byte stream stalls, the controller holds the serial clock low just before the edge that would finish the next byte, so no data is dropped.

Top module: `dual_read_ctrl`

## Requirements
- R1: After reset, and between transactions: flash_cs_n is 1, flash_sck is 0, flash_io0_oe is 0, req_ready is 1 and out_valid is 0.
- R2: A request is accepted on a clock where req_valid and req_ready are both 1. Chip select then falls, and the command byte 0x3B goes out MSB first on flash_io0_o, one bit for each of the serial clocks 0 to 7. flash_io0_oe is 1 during these clocks.
- R3: All 24 bits of req_addr, including bits 23 to 21, go out unchanged and MSB first on flash_io0_o, one bit for each of the serial clocks 8 to 31.
- R4: Eight dummy serial clocks (32 to 39) follow the address. flash_io0_oe falls at the falling edge that ends clock 31 and stays 0 until chip select rises. It is therefore already 0 when the flash starts driving, at the falling edge that ends clock 39.
- R5: From serial clock 40 on, each byte takes four clocks, MSB pair first. In each clock, flash_io1_i carries the odd bit (7, 5, 3, 1) and flash_io0_i carries the even bit (6, 4, 2, 0). The first byte belongs to the start address and each later byte to the next address.
- R6: Exactly req_len_m1 + 1 bytes are delivered. Chip select then rises, with flash_sck low, one half period after the last falling edge.
- R7: Each serial-clock half period lasts DIV system clocks when the clock is not paused. The first rising edge comes DIV system clocks after chip select falls. flash_io0_o changes only while flash_sck is low.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_data hold. The serial clock stops after at most three more rising edges, before the edge that would finish the next byte. No byte is lost or repeated.
- R9: req_ready is 0 whenever chip select is low, so a request made during a transaction is not taken until that transaction has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 24 | Start byte address |
| req_len_m1 | input | LEN_W | Byte count minus one |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_sck | output | 1 | Serial clock, idles low |
| flash_io0_o | output | 1 | Value driven on the shared line |
| flash_io0_oe | output | 1 | Output enable for the shared line |
| flash_io0_i | input | 1 | Value read from the shared line (even bits) |
| flash_io1_i | input | 1 | Flash data output line (odd bits) |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Assembled byte |

## Verification
Chip select falls on the clock after a request is accepted. Every serial-clock edge after that comes DIV system clocks after the one before it. A byte becomes valid on the same system clock as the rising edge of its fourth pair, and chip select rises DIV system clocks after the last falling edge. The bench holds a cycle counter and a flash model that follows the serial-clock edges. It checks each edge against the previous one and drives its bits on the falling edges, a full half period before the controller samples them. The bench samples ports on the falling system-clock edge, and it counts serial rising edges over a fixed window to check that a stall freezes the clock after exactly three more rising edges.

// File: rtl/dr_pkg.sv
package dr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2,
        ST_TAIL = 2'd3
    } dr_state_e;

    localparam logic [7:0] DR_OPCODE = 8'h3B;
    localparam int DR_ADDR_W = 24;
    localparam int DR_DUMMY_CLKS = 8;
endpackage

// File: rtl/dr_sck_div.sv
module dr_sck_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = 1'b0;
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == TOP) begin
            if (!hold) begin
                tick  = 1'b1;
                cnt_d = '0;
            end
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dr_byte_rx.sv
module dr_byte_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cap,
    input  logic       odd_bit,
    input  logic       even_bit,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       last_pair,
    output logic       slot_free
);
    typedef struct packed {
        logic [1:0] pair;
        logic [5:0] sr;
        logic       dv;
        logic [7:0] data;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (rx_q.dv && out_ready) rx_d.dv = 1'b0;
        if (clr) begin
            rx_d.pair = '0;
        end else if (cap) begin
            rx_d.sr   = {rx_q.sr[3:0], odd_bit, even_bit};
            rx_d.pair = rx_q.pair + 2'd1;
            if (rx_q.pair == 2'd3) begin
                rx_d.data = {rx_q.sr, odd_bit, even_bit};
                rx_d.dv   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign out_valid = rx_q.dv;
    assign out_data  = rx_q.data;
    assign last_pair = (rx_q.pair == 2'd3);
    assign slot_free = !rx_q.dv || out_ready;
endmodule

// File: rtl/dual_read_ctrl.sv
module dual_read_ctrl #(
    parameter int DIV   = 2,
    parameter int LEN_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [dr_pkg::DR_ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]            req_len_m1,
    output logic                        flash_cs_n,
    output logic                        flash_sck,
    output logic                        flash_io0_o,
    output logic                        flash_io0_oe,
    input  logic                        flash_io0_i,
    input  logic                        flash_io1_i,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [7:0]                  out_data
);
    import dr_pkg::*;

    localparam int SH_W     = 8 + DR_ADDR_W;
    localparam int HDR_CLKS = SH_W + DR_DUMMY_CLKS;
    localparam int CN_W     = $clog2(HDR_CLKS + 1);
    localparam logic [CN_W-1:0] LAST_SH  = CN_W'(SH_W - 1);
    localparam logic [CN_W-1:0] LAST_HDR = CN_W'(HDR_CLKS - 1);
    localparam logic [CN_W-1:0] SAT_CN   = CN_W'(HDR_CLKS);

    typedef struct packed {
        dr_state_e       st;
        logic            sck;
        logic            cs_n;
        logic            oe;
        logic            io0;
        logic [SH_W-1:0] sh;
        logic [CN_W-1:0] clk_no;
        logic [LEN_W-1:0] left;
        logic            fin;
    } seq_t;

    seq_t s_d, s_q;

    logic tick, hold, run, rise, fall, cap, clr;
    logic last_pair, slot_free;
    logic active;

    dr_sck_div #(.DIV(DIV)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .hold  (hold),
        .tick  (tick)
    );

    dr_byte_rx rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .cap       (cap),
        .odd_bit   (flash_io1_i),
        .even_bit  (flash_io0_i),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .last_pair (last_pair),
        .slot_free (slot_free)
    );

    assign run    = (s_q.st != ST_IDLE);
    assign active = (s_q.st == ST_HDR) || (s_q.st == ST_DATA);
    assign hold   = (s_q.st == ST_DATA) && !s_q.sck && last_pair && !slot_free;
    assign rise   = tick && active && !s_q.sck;
    assign fall   = tick && active && s_q.sck;
    assign cap    = rise && (s_q.st == ST_DATA);
    assign clr    = (s_q.st == ST_IDLE);

    always_comb begin
        s_d       = s_q;
        req_ready = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    s_d.st     = ST_HDR;
                    s_d.cs_n   = 1'b0;
                    s_d.sck    = 1'b0;
                    s_d.oe     = 1'b1;
                    s_d.sh     = {DR_OPCODE, req_addr};
                    s_d.io0    = DR_OPCODE[7];
                    s_d.clk_no = '0;
                    s_d.left   = req_len_m1;
                    s_d.fin    = 1'b0;
                end
            end
            ST_HDR, ST_DATA: begin
                if (tick) s_d.sck = !s_q.sck;
                if (fall) begin
                    if (s_q.clk_no != SAT_CN) s_d.clk_no = s_q.clk_no + 1'b1;
                    if (s_q.st == ST_HDR) begin
                        if (s_q.clk_no < LAST_SH) begin
                            s_d.sh  = s_q.sh << 1;
                            s_d.io0 = s_q.sh[SH_W-2];
                        end else if (s_q.clk_no == LAST_SH) begin
                            s_d.oe  = 1'b0;
                            s_d.io0 = 1'b0;
                        end
                        if (s_q.clk_no == LAST_HDR) s_d.st = ST_DATA;
                    end else if (s_q.fin) begin
                        s_d.st = ST_TAIL;
                    end
                end
                if (cap && last_pair) begin
                    if (s_q.left == '0) s_d.fin  = 1'b1;
                    else                s_d.left = s_q.left - 1'b1;
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    s_d.cs_n = 1'b1;
                    s_d.st   = ST_IDLE;
                    s_d.fin  = 1'b0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign flash_cs_n   = s_q.cs_n;
    assign flash_sck    = s_q.sck;
    assign flash_io0_o  = s_q.io0;
    assign flash_io0_oe = s_q.oe;
endmodule

// File: rtl/dr_checker.sv
module dr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       flash_cs_n,
    input logic       flash_sck,
    input logic       flash_io0_o,
    input logic       flash_io0_oe,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);
    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> !req_ready);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    sck_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_sck) |-> !flash_cs_n);

    // R7
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flash_io0_o) |-> !flash_sck);

    // R6
    cs_rise_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_cs_n) |-> (!flash_sck && !flash_io0_oe));

    // R2
    oe_starts_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_io0_oe) |-> $fell(flash_cs_n));
endmodule

bind dual_read_ctrl dr_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .flash_cs_n   (flash_cs_n),
    .flash_sck    (flash_sck),
    .flash_io0_o  (flash_io0_o),
    .flash_io0_oe (flash_io0_oe),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data)
);

// File: tb/dual_read_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_read_ctrl_tb_top;
    localparam int DIV   = 2;
    localparam int LEN_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [23:0] req_addr = '0;
    logic [LEN_W-1:0] req_len_m1 = '0;
    logic flash_cs_n, flash_sck, flash_io0_o, flash_io0_oe;
    logic m_io0 = 1'b0, m_io1 = 1'b0;
    logic io0_bus;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [7:0] out_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    assign io0_bus = flash_io0_oe ? flash_io0_o : m_io0;

    dual_read_ctrl #(.DIV(DIV), .LEN_W(LEN_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_len_m1   (req_len_m1),
        .flash_cs_n   (flash_cs_n),
        .flash_sck    (flash_sck),
        .flash_io0_o  (flash_io0_o),
        .flash_io0_oe (flash_io0_oe),
        .flash_io0_i  (io0_bus),
        .flash_io1_i  (m_io1),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data)
    );

    function automatic logic [7:0] fexp(input logic [23:0] a);
        logic [20:0] w;
        w = a[20:0];
        return w[7:0] ^ w[15:8] ^ {w[20:16], 3'b101};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Flash model
    int m_rise = 0;
    int sck_rises = 0;
    int last_edge = 0;
    int m_oe_err = 0;
    int m_gap_err = 0;
    logic [7:0]  m_cmd = '0;
    logic [23:0] m_addr = '0;

    always @(negedge flash_cs_n) begin
        m_rise    = 0;
        m_cmd     = '0;
        m_addr    = '0;
        last_edge = cyc;
    end

    always @(posedge flash_sck) begin
        if (!flash_cs_n) begin
            sck_rises++;
            if (m_rise < 40 && (cyc - last_edge) != DIV) m_gap_err++;
            last_edge = cyc;
            if (m_rise < 32) begin
                if (flash_io0_oe !== 1'b1) m_oe_err++;
                if (m_rise < 8) m_cmd = {m_cmd[6:0], flash_io0_o};
                else            m_addr = {m_addr[22:0], flash_io0_o};
            end else if (flash_io0_oe !== 1'b0) begin
                m_oe_err++;
            end
            m_rise++;
        end
    end

    always @(negedge flash_sck) begin
        if (!flash_cs_n) begin
            if (m_rise <= 40 && (cyc - last_edge) != DIV) m_gap_err++;
            last_edge = cyc;
            if (m_rise >= 40) begin
                int k, b, p;
                logic [7:0] v;
                k = m_rise - 40;
                b = k / 4;
                p = k % 4;
                v = fexp(m_addr + 24'(b));
                if (flash_io0_oe !== 1'b0) m_oe_err++;
                m_io1 = v[7 - 2*p];
                m_io0 = v[6 - 2*p];
            end
        end
    end

    // Byte collector
    logic [7:0] rx_b [0:63];
    int rx_n = 0;
    always @(posedge clk) begin
        if (out_valid && out_ready && rx_n < 64) begin
            rx_b[rx_n] = out_data;
            rx_n++;
        end
    end

    // Request interface monitor (R9)
    int busy_ready_err = 0;
    always @(negedge clk) begin
        if (rst_n && !flash_cs_n && req_ready) busy_ready_err++;
    end

    task automatic run_txn(input logic [23:0] addr, input int len_m1, input bit stall);
        int n, r0, wait_c;
        logic [7:0] d0;
        n = len_m1 + 1;
        m_oe_err  = 0;
        m_gap_err = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rx_n = 0;
        req_addr   = addr;
        req_len_m1 = LEN_W'(len_m1);
        req_valid  = 1'b1;
        if (stall) out_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(flash_cs_n == 1'b0, "R2", "cs low after accept", flash_cs_n, 0);
        chk(req_ready == 1'b0, "R9", "not ready while busy", req_ready, 0);
        if (stall) begin
            while (!out_valid) @(negedge clk);
            r0 = sck_rises;
            d0 = out_data;
            repeat (60) @(negedge clk);
            chk(sck_rises - r0 == 3, "R8", "rises while stalled", sck_rises - r0, 3);
            chk(out_valid && out_data == d0 && d0 == fexp(addr), "R8",
                "held byte", out_data, fexp(addr));
            out_ready = 1'b1;
        end
        while (!flash_cs_n) @(negedge clk);
        chk(flash_sck == 1'b0, "R6", "sck low at cs rise", flash_sck, 0);
        wait_c = 0;
        while (rx_n < n && wait_c < 20) begin
            @(negedge clk);
            wait_c++;
        end
        repeat (3) @(negedge clk);
        chk(m_cmd == 8'h3B, "R2", "command byte", m_cmd, 8'h3B);
        chk(m_addr == addr, "R3", "address", m_addr, addr);
        chk(m_oe_err == 0, "R4", "line release timing", m_oe_err, 0);
        chk(m_gap_err == 0, "R7", "half period", m_gap_err, 0);
        chk(m_rise == 40 + 4*n, "R5", "serial clocks", m_rise, 40 + 4*n);
        chk(rx_n == n, "R6", "byte count", rx_n, n);
        for (int i = 0; i < n && i < rx_n; i++) begin
            chk(rx_b[i] == fexp(addr + 24'(i)), "R5", $sformatf("byte %0d", i),
                rx_b[i], fexp(addr + 24'(i)));
        end
        chk(flash_cs_n && !flash_sck && !flash_io0_oe && req_ready && !out_valid,
            "R1", "idle between transactions",
            {flash_cs_n, flash_sck, flash_io0_oe, req_ready, out_valid}, 5'b10010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(flash_cs_n && !flash_sck && !flash_io0_oe && req_ready && !out_valid,
            "R1", "reset state",
            {flash_cs_n, flash_sck, flash_io0_oe, req_ready, out_valid}, 5'b10010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            run_txn((24'(i) * 24'h13579B) ^ 24'hA00000, i, 1'b0);
        end
        run_txn(24'hE1FFFE, 2, 1'b0);
        run_txn(24'h000000, 0, 1'b0);
        run_txn(24'h1FFFFF, 4, 1'b1);
        run_txn(24'h7ABCDE, 3, 1'b1);
        chk(busy_ready_err == 0, "R9", "ready seen while busy", busy_ready_err, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule